// File: doc/BRIEF.md
# Mixed-Sign Q15 / Integer Multiplier Datapath

This block is the multiply stage of a DSP datapath. It takes two 16-bit operands. Each operand has its own signed/unsigned control, so signed, unsigned and mixed-sign products all come from one 17x17-bit two's complement core. Before the multiply, each operand is widened to 17 bits. Bit 16 is filled with zero for an unsigned operand and with the operand's sign for a signed one.

A size control chooses between word operands and byte operands. Word operands give a 32-bit product. Byte operands use only the low 8 bits of each input and give a 16-bit product. A mode control chooses the alignment of the result. Integer alignment is the plain product. Fractional alignment treats the inputs as Q15 and gives a 1.31 result. The 33-bit aligned result comes out as a 32-bit product. It also comes out sign-extended to 40 bits, ready for an accumulator adder.

A parameter adds a single output register that is cleared by reset. Without it, the unit is purely combinational.

Top module: `qmul_unit`

## Requirements
- R1: In word mode (`byte_i`=0), an operand whose sign control is 1 is sign-extended from bit 15 into core bit 16. An operand whose sign control is 0 is zero-extended.
- R2: In byte mode (`byte_i`=1), only bits 7:0 of each operand are used. They are sign-extended (control 1) or zero-extended (control 0) from bit 7. Bits 15:8 have no effect on either output.
- R3: With both sign controls 0, integer word mode gives the exact unsigned 32-bit product, and `acc_o[39:32]` is zero.
- R4: With both sign controls 1, integer word mode gives the two's complement product of the two signed values.
- R5: With the two sign controls different, the product is that of one signed value and one unsigned value.
- R6: `acc_o` equals the 33-bit aligned result sign-extended from its bit 32.
- R7: With `frac_i`=1, bits 32:1 of the aligned result are bits 31:0 of the integer product, and bit 0 is zero. With `frac_i`=0, the aligned result is the integer product.
- R8: In byte mode, `prod_o[31:16]` is zero and `prod_o[15:0]` holds bits 15:0 of the aligned result. In word mode, `prod_o` equals `acc_o[31:0]`.
- R9: In fractional word mode with both operands signed, 0x8000 times 0x8000 gives `prod_o`=0x80000000 and `acc_o`=0x0080000000.
- R10: With `OUT_REG`=1, outputs follow the inputs with one clock of latency, and an active `rst_ni` forces both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| a_sgn_i | input | 1 | 1: operand a is signed, 0: unsigned |
| b_sgn_i | input | 1 | 1: operand b is signed, 0: unsigned |
| frac_i | input | 1 | 1: fractional 1.31 alignment, 0: integer |
| byte_i | input | 1 | 1: byte operands, 0: word operands |
| prod_o | output | 32 | Aligned product (16-bit result in low half for bytes) |
| acc_o | output | 40 | Aligned 33-bit result sign-extended to 40 bits |

## Verification
The assertions assume that the mode and sign controls stay paired with the operands they arrive with. They also assume that the registered copy of those controls describes the result currently on the outputs. The stimulus respects this by changing every input together on the falling edge and sampling one cycle later.

The properties do not depend on any particular operand value, except the full-scale negative check, which looks only at that exact operand pair. The stimulus covers the extreme codes 0x0000, 0x7FFF, 0x8000 and 0xFFFF, both byte polarities with nonzero upper bytes, and random values. It uses unsigned fractional inputs only where the discarded top bit is defined by R7.

// File: rtl/qmul_pkg.sv
package qmul_pkg;
  localparam int unsigned OP_W   = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CORE_W = OP_W + 1;
  localparam int unsigned RAW_W  = 2 * OP_W + 1;
  localparam int unsigned ACC_W  = 40;

  typedef struct packed {
    logic a_sgn;
    logic b_sgn;
    logic frac;
    logic byte_md;
  } qmul_mode_t;
endpackage

// File: rtl/qmul_opnd_ext.sv
module qmul_opnd_ext #(
  parameter int unsigned OP_W   = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CORE_W = OP_W + 1
) (
  input  logic [OP_W-1:0]   opnd_i,
  input  logic              sgn_i,
  input  logic              byte_i,
  output logic [CORE_W-1:0] ext_o
);
  localparam int unsigned WPAD = CORE_W - OP_W;
  localparam int unsigned BPAD = CORE_W - BYTE_W;

  logic w_fill, b_fill;

  always_comb begin
    w_fill = sgn_i & opnd_i[OP_W-1];
    b_fill = sgn_i & opnd_i[BYTE_W-1];
    if (byte_i) ext_o = {{BPAD{b_fill}}, opnd_i[BYTE_W-1:0]};
    else        ext_o = {{WPAD{w_fill}}, opnd_i};
  end
endmodule

// File: rtl/qmul_core.sv
module qmul_core #(
  parameter int unsigned CORE_W = 17
) (
  input  logic [CORE_W-1:0]   a_i,
  input  logic [CORE_W-1:0]   b_i,
  output logic [2*CORE_W-1:0] p_o
);
  logic signed [2*CORE_W-1:0] a_s, b_s;

  always_comb begin
    a_s = {{CORE_W{a_i[CORE_W-1]}}, a_i};
    b_s = {{CORE_W{b_i[CORE_W-1]}}, b_i};
  end

  assign p_o = a_s * b_s;
endmodule

// File: rtl/qmul_scaler.sv
module qmul_scaler #(
  parameter int unsigned PROD_W = 34,
  parameter int unsigned RAW_W  = 33,
  parameter int unsigned ACC_W  = 40
) (
  input  logic [PROD_W-1:0] prod_i,
  input  logic              frac_i,
  output logic [RAW_W-1:0]  raw_o,
  output logic [ACC_W-1:0]  acc_o
);
  localparam int unsigned XPAD = ACC_W - RAW_W;

  logic unused_hi;
  assign unused_hi = |prod_i[PROD_W-1:RAW_W];

  // Q31 alignment: drop redundant sign, radix after bit 31
  always_comb begin
    if (frac_i) raw_o = {prod_i[RAW_W-2:0], 1'b0};
    else        raw_o = prod_i[RAW_W-1:0];
    acc_o = {{XPAD{raw_o[RAW_W-1]}}, raw_o};
  end
endmodule

// File: rtl/qmul_unit.sv
module qmul_unit
  import qmul_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  input  logic              a_sgn_i,
  input  logic              b_sgn_i,
  input  logic              frac_i,
  input  logic              byte_i,
  output logic [2*OP_W-1:0] prod_o,
  output logic [ACC_W-1:0]  acc_o
);
  localparam int unsigned RES_W  = 2 * OP_W;
  localparam int unsigned BRES_W = 2 * BYTE_W;
  localparam int unsigned PROD_W = 2 * CORE_W;

  logic [1:0][OP_W-1:0]   opnd;
  logic [1:0]             sgn;
  logic [1:0][CORE_W-1:0] ext;
  logic [PROD_W-1:0]      core_p;
  logic [RAW_W-1:0]       raw;
  logic [ACC_W-1:0]       acc_c;
  logic [RES_W-1:0]       prod_c;
  qmul_mode_t             mode_c, mode_q;

  assign opnd   = {b_i, a_i};
  assign sgn    = {b_sgn_i, a_sgn_i};
  assign mode_c = '{a_sgn: a_sgn_i, b_sgn: b_sgn_i, frac: frac_i, byte_md: byte_i};

  for (genvar g = 0; g < 2; g++) begin : g_ext
    qmul_opnd_ext #(
      .OP_W  (OP_W),
      .BYTE_W(BYTE_W),
      .CORE_W(CORE_W)
    ) u_ext (
      .opnd_i(opnd[g]),
      .sgn_i (sgn[g]),
      .byte_i(byte_i),
      .ext_o (ext[g])
    );
  end

  qmul_core #(.CORE_W(CORE_W)) u_core (
    .a_i(ext[0]),
    .b_i(ext[1]),
    .p_o(core_p)
  );

  qmul_scaler #(
    .PROD_W(PROD_W),
    .RAW_W (RAW_W),
    .ACC_W (ACC_W)
  ) u_scl (
    .prod_i(core_p),
    .frac_i(frac_i),
    .raw_o (raw),
    .acc_o (acc_c)
  );

  always_comb begin
    if (byte_i) prod_c = {{(RES_W-BRES_W){1'b0}}, raw[BRES_W-1:0]};
    else        prod_c = raw[RES_W-1:0];
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prod_o <= '0;
        acc_o  <= '0;
        mode_q <= '0;
      end else begin
        prod_o <= prod_c;
        acc_o  <= acc_c;
        mode_q <= mode_c;
      end
    end
  end else begin : g_comb
    assign prod_o = prod_c;
    assign acc_o  = acc_c;
    assign mode_q = mode_c;
  end

  assert_acc_ext_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o[ACC_W-1:RAW_W-1] == '0) || (acc_o[ACC_W-1:RAW_W-1] == '1));

  assert_word_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q.byte_md |-> (acc_o[RES_W-1:0] == prod_o));

  assert_byte_hi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q.byte_md |-> (prod_o[RES_W-1:BRES_W] == '0));

  assert_uu_nonneg_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q.a_sgn && !mode_q.b_sgn && !mode_q.frac) |-> (acc_o[ACC_W-1] == 1'b0));

  assert_frac_lsb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q.frac |-> (acc_o[0] == 1'b0));

  if (OUT_REG) begin : g_lat_chk
    assert_neg_one_sq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_i == 16'h8000 && b_i == 16'h8000 && a_sgn_i && b_sgn_i && frac_i && !byte_i)
      |=> (prod_o == 32'h8000_0000 && acc_o == 40'h00_8000_0000));
  end
endmodule

// File: tb/sim_qmul_unit.sv
module sim_qmul_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic        as;
    logic        bs;
    logic        fr;
    logic        by;
    logic [31:0] ep;
    logic [39:0] ea;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFE_0001, 40'h00_FFFE_0001},
    '{16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0001, 40'h00_0000_0001},
    '{16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFF_0001, 40'hFF_FFFF_0001},
    '{16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0, 1'b0, 32'h4000_0000, 40'h00_4000_0000},
    '{16'h8000, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b0, 32'h8000_0000, 40'h00_8000_0000},
    '{16'h4000, 16'h4000, 1'b1, 1'b1, 1'b1, 1'b0, 32'h2000_0000, 40'h00_2000_0000},
    '{16'h8000, 16'h4000, 1'b1, 1'b1, 1'b1, 1'b0, 32'hC000_0000, 40'hFF_C000_0000},
    '{16'h12FF, 16'h34FF, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_FE01, 40'h00_0000_FE01},
    '{16'h12FF, 16'h34FF, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_0001, 40'h00_0000_0001},
    '{16'hA5FF, 16'h5A80, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_8080, 40'hFF_FFFF_8080},
    '{16'h8000, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 32'h8000_8000, 40'hFF_8000_8000},
    '{16'h1234, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0001_2340, 40'h00_0001_2340},
    '{16'h7F80, 16'h3380, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_8000, 40'h00_0000_8000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic        as = 1'b0, bs = 1'b0, fr = 1'b0, by = 1'b0;
  logic [31:0] prod;
  logic [39:0] acc;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qmul_unit #(.OUT_REG(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b),
    .a_sgn_i(as), .b_sgn_i(bs), .frac_i(fr), .byte_i(by),
    .prod_o(prod), .acc_o(acc)
  );

  function automatic logic [71:0] model(logic [15:0] x, logic [15:0] y,
                                        logic xs, logic ys, logic f, logic bm);
    longint xv, yv, p;
    logic [32:0] r;
    logic [31:0] po;
    if (bm) begin
      xv = xs ? longint'($signed(x[7:0])) : longint'(x[7:0]);
      yv = ys ? longint'($signed(y[7:0])) : longint'(y[7:0]);
    end else begin
      xv = xs ? longint'($signed(x)) : longint'(x);
      yv = ys ? longint'($signed(y)) : longint'(y);
    end
    p = xv * yv;
    if (f) p = p * 2;
    r  = p[32:0];
    po = bm ? {16'h0000, r[15:0]} : r[31:0];
    return {po, {7{r[32]}}, r};
  endfunction

  task automatic chk(string req, logic [31:0] ep, logic [39:0] ea);
    checks++;
    if (prod !== ep || acc !== ea) begin
      errors++;
      $display("FAIL %s prod=%h acc=%h expected prod=%h acc=%h", req, prod, acc, ep, ea);
    end
  endtask

  task automatic drive(logic [15:0] x, logic [15:0] y, logic xs, logic ys, logic f, logic bm);
    @(negedge clk);
    a = x; b = y; as = xs; bs = ys; fr = f; by = bm;
    @(negedge clk);
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [71:0] m;
    a = 16'h7FFF; b = 16'h7FFF; as = 1'b1; bs = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 reset", 32'h0, 40'h0);
    rst_n = 1'b1;

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].a, VECS[i].b, VECS[i].as, VECS[i].bs, VECS[i].fr, VECS[i].by);
      chk($sformatf("R1-table vec %0d", i), VECS[i].ep, VECS[i].ea);
    end

    // R9: full-scale negative squared in fractional mode
    drive(16'h8000, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R9", 32'h8000_0000, 40'h00_8000_0000);

    // R2: upper bytes ignored
    drive(16'h0081, 16'h0003, 1'b1, 1'b0, 1'b0, 1'b1);
    m = model(16'h0081, 16'h0003, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R2 base", m[71:40], m[39:0]);
    drive(16'hFF81, 16'hC303, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R2 upper ignored", m[71:40], m[39:0]);

    // R1: sign control alone flips bit 16 fill
    drive(16'h8001, 16'h0002, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R1 zero fill", 32'h0001_0002, 40'h00_0001_0002);
    drive(16'h8001, 16'h0002, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R1 sign fill", 32'hFFFF_0002, 40'hFF_FFFF_0002);

    // R10: output holds until next edge
    drive(16'h0003, 16'h0005, 1'b0, 1'b0, 1'b0, 1'b0);
    a = 16'h0007;
    #1;
    chk("R10 latency", 32'h0000_000F, 40'h00_0000_000F);
    @(negedge clk);
    chk("R10 update", 32'h0000_0023, 40'h00_0000_0023);

    // random sweep: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 400; i++) begin
      logic [15:0] x, y;
      logic [3:0]  md;
      x  = 16'($urandom);
      y  = 16'($urandom);
      md = 4'($urandom);
      drive(x, y, md[0], md[1], md[2], md[3]);
      m = model(x, y, md[0], md[1], md[2], md[3]);
      chk("R3/R4/R5 R6 R7 R8 sweep", m[71:40], m[39:0]);
    end

    // reset mid-stream clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 async reset", 32'h0, 40'h0);
    @(negedge clk);
    rst_n = 1'b1;
    report();
  end
endmodule